// File: doc/BRIEF.md
# Per-Channel Address Offset Predictor

The block watches the byte offsets of accesses arriving on several independent transfer channels and keeps a small history for each one. For every access it works out the step from that channel's previous offset. If the same step has already been seen twice in a row, the access can be predicted, and the link may send a compact frame with no offset field. Any other access needs a full frame that carries its offset. Accesses to other channels in between do not disturb a channel's history. Steps larger than 512 bytes in either direction are never learned.

The same logic runs at both ends of the link. In transmit mode it flags which accesses may go compact. In receive mode a compact frame carries no offset, so the block rebuilds it as the channel's previous offset plus the learned step, and updates the history exactly as the sender did. The two ends therefore stay in step without the offset crossing the link. A global enable can force full frames at all times while the histories keep learning.

Top module: `ofs_predictor`

## Requirements
- R1: Each access strobed on `acc_valid_i` produces `out_valid_o` high on the next clock cycle, together with `hit_o`, `ofs_o` and `compact_o`; a cycle without a strobe gives `out_valid_o` low in the following cycle.
- R2: Each channel keeps its own history. Accesses to other channels between two accesses to one channel do not change that channel's prediction.
- R3: The step of an access is its offset minus the previous offset of the same channel, modulo 2^16 and read as a signed value. `hit_o` is 1 only when the same step has already occurred on the two previous consecutive accesses to that channel. With a constant stride, the first hit is on the fourth access.
- R4: `compact_o` is 1 only when `hit_o` is 1 and `enable_i` is 1 (1 = compact frame without offset, 0 = full frame with offset).
- R5: A step that differs from the learned step clears the channel's prediction. That access is a miss, the next access that repeats the new step is also a miss, and the access after that is a hit.
- R6: A step whose magnitude exceeds 512 is a miss and is not learned. A step of exactly +512 or -512 is learned normally.
- R7: In receive mode (`rx_mode_i`=1) with `rx_compact_i`=1, `acc_ofs_i` is ignored. `ofs_o` equals the channel's previous offset plus its learned step, and that rebuilt offset updates the history.
- R8: In transmit mode, and in receive mode with `rx_compact_i`=0, `ofs_o` equals the `acc_ofs_i` of the access.
- R9: Synchronous reset clears every channel history and `out_valid_o`. After reset, the first access to any channel is a miss.
- R10: With `enable_i`=0, `compact_o` stays 0 but the histories keep learning. A hit on the first access after enable returns shows this.
- R11: Offsets wrap modulo 2^16. A constant stride that crosses 0xFFFF to 0x0000 is still predicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Global enable for compact frames |
| acc_valid_i | input | 1 | Access strobe |
| acc_chan_i | input | 2 | Channel index |
| acc_ofs_i | input | 16 | Byte offset of the access (ignored for compact receive) |
| rx_mode_i | input | 1 | 1 = receive mode, 0 = transmit mode |
| rx_compact_i | input | 1 | In receive mode: incoming frame is compact |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| hit_o | output | 1 | Offset was predicted |
| ofs_o | output | 16 | Full (possibly rebuilt) offset |
| compact_o | output | 1 | Frame type: 1 compact, 0 full |

## Verification
The hardest case to reach is a channel whose history has been learned, broken and learned again while other channels' accesses are interleaved, with steps that sit exactly on the ±512 limit or wrap past 0xFFFF. Directed sequences build this up one access at a time, starting from a reset in every scenario. They interleave channels with opposite strides, insert a mismatch after a lock, and step across the limit and the wrap point. Receive mode is checked by learning a stride from full frames and then sending compact frames whose offset input carries garbage. The rebuilt offsets must continue the stride.

// File: rtl/ofs_pred_pkg.sv
package ofs_pred_pkg;
  typedef enum logic [1:0] {
    CF_EMPTY  = 2'd0,
    CF_BASE   = 2'd1,
    CF_ONCE   = 2'd2,
    CF_LOCKED = 2'd3
  } conf_e;
endpackage

// File: rtl/ofs_pred_table.sv
module ofs_pred_table
  import ofs_pred_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [OFS_W-1:0] rd_prev,
  output logic [OFS_W-1:0] rd_step,
  output conf_e            rd_conf,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [OFS_W-1:0] wr_prev,
  input  logic [OFS_W-1:0] wr_step,
  input  conf_e            wr_conf
);
  logic [OFS_W-1:0] prev_q [NUM_CH];
  logic [OFS_W-1:0] step_q [NUM_CH];
  conf_e            conf_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= '0;
        step_q[g] <= '0;
        conf_q[g] <= CF_EMPTY;
      end else if (wr_en && (wr_ch == CH_W'(g))) begin
        prev_q[g] <= wr_prev;
        step_q[g] <= wr_step;
        conf_q[g] <= wr_conf;
      end
    end
  end

  assign rd_prev = prev_q[rd_ch];
  assign rd_step = step_q[rd_ch];
  assign rd_conf = conf_q[rd_ch];
endmodule

// File: rtl/ofs_pred_eval.sv
module ofs_pred_eval
  import ofs_pred_pkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int MAX_STEP = 512
) (
  input  logic [OFS_W-1:0] cur_prev,
  input  logic [OFS_W-1:0] cur_step,
  input  conf_e            cur_conf,
  input  logic [OFS_W-1:0] acc_ofs,
  input  logic             rx_mode,
  input  logic             rx_compact,
  output logic [OFS_W-1:0] eff_ofs,
  output logic             hit,
  output logic [OFS_W-1:0] nxt_prev,
  output logic [OFS_W-1:0] nxt_step,
  output conf_e            nxt_conf
);
  localparam logic signed [OFS_W-1:0] LIM_P = OFS_W'(MAX_STEP);
  localparam logic signed [OFS_W-1:0] LIM_N = -LIM_P;

  logic [OFS_W-1:0] step_now;
  logic             in_range;
  logic             same_step;

  always_comb begin
    eff_ofs   = (rx_mode && rx_compact) ? (cur_prev + cur_step) : acc_ofs;
    step_now  = eff_ofs - cur_prev;
    in_range  = ($signed(step_now) <= LIM_P) && ($signed(step_now) >= LIM_N);
    same_step = (step_now == cur_step);
    hit       = (cur_conf == CF_LOCKED) && same_step;

    nxt_prev = eff_ofs;
    nxt_step = cur_step;
    nxt_conf = cur_conf;
    if (cur_conf == CF_EMPTY) begin
      nxt_conf = CF_BASE;
      nxt_step = '0;
    end else if (!in_range) begin
      nxt_conf = CF_BASE;
      nxt_step = '0;
    end else if ((cur_conf == CF_ONCE || cur_conf == CF_LOCKED) && same_step) begin
      nxt_conf = CF_LOCKED;
    end else begin
      nxt_conf = CF_ONCE;
      nxt_step = step_now;
    end
  end
endmodule

// File: rtl/ofs_predictor.sv
module ofs_predictor
  import ofs_pred_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int OFS_W    = 16,
  parameter int MAX_STEP = 512,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             acc_valid_i,
  input  logic [CH_W-1:0]  acc_chan_i,
  input  logic [OFS_W-1:0] acc_ofs_i,
  input  logic             rx_mode_i,
  input  logic             rx_compact_i,
  output logic             out_valid_o,
  output logic             hit_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             compact_o
);
  logic [OFS_W-1:0] cur_prev, cur_step, nxt_prev, nxt_step, eff_ofs;
  conf_e            cur_conf, nxt_conf;
  logic             hit_c;

  ofs_pred_table #(.NUM_CH(NUM_CH), .OFS_W(OFS_W)) i_table (
    .clk     (clk),
    .rst     (rst),
    .rd_ch   (acc_chan_i),
    .rd_prev (cur_prev),
    .rd_step (cur_step),
    .rd_conf (cur_conf),
    .wr_en   (acc_valid_i),
    .wr_ch   (acc_chan_i),
    .wr_prev (nxt_prev),
    .wr_step (nxt_step),
    .wr_conf (nxt_conf)
  );

  ofs_pred_eval #(.OFS_W(OFS_W), .MAX_STEP(MAX_STEP)) i_eval (
    .cur_prev   (cur_prev),
    .cur_step   (cur_step),
    .cur_conf   (cur_conf),
    .acc_ofs    (acc_ofs_i),
    .rx_mode    (rx_mode_i),
    .rx_compact (rx_compact_i),
    .eff_ofs    (eff_ofs),
    .hit        (hit_c),
    .nxt_prev   (nxt_prev),
    .nxt_step   (nxt_step),
    .nxt_conf   (nxt_conf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      ofs_o       <= '0;
      compact_o   <= 1'b0;
    end else begin
      out_valid_o <= acc_valid_i;
      if (acc_valid_i) begin
        hit_o     <= hit_c;
        ofs_o     <= eff_ofs;
        compact_o <= hit_c && enable_i;
      end
    end
  end
endmodule

// File: rtl/ofs_predictor_chk.sv
module ofs_predictor_chk #(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             enable_i,
  input logic             acc_valid_i,
  input logic [CH_W-1:0]  acc_chan_i,
  input logic [OFS_W-1:0] acc_ofs_i,
  input logic             rx_mode_i,
  input logic             rx_compact_i,
  input logic             out_valid_o,
  input logic             hit_o,
  input logic [OFS_W-1:0] ofs_o,
  input logic             compact_o
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i |=> out_valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid_i |=> !out_valid_o);
  a_r4_compact_needs_hit: assert property (@(posedge clk) disable iff (rst)
    compact_o |-> hit_o);
  a_r10_disable_forces_full: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !enable_i) |=> !compact_o);
  a_r8_tx_ofs_passthrough: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_i && !rx_mode_i) |=> (ofs_o == $past(acc_ofs_i)));
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> !out_valid_o);
endmodule

bind ofs_predictor ofs_predictor_chk #(.NUM_CH(NUM_CH), .OFS_W(OFS_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .enable_i     (enable_i),
  .acc_valid_i  (acc_valid_i),
  .acc_chan_i   (acc_chan_i),
  .acc_ofs_i    (acc_ofs_i),
  .rx_mode_i    (rx_mode_i),
  .rx_compact_i (rx_compact_i),
  .out_valid_o  (out_valid_o),
  .hit_o        (hit_o),
  .ofs_o        (ofs_o),
  .compact_o    (compact_o)
);

// File: tb/test_ofs_predictor.sv
module test_ofs_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        vld = 1'b0;
  logic [1:0]  ch = '0;
  logic [15:0] ofs = '0;
  logic        rxm = 1'b0;
  logic        rxc = 1'b0;
  logic        ov, hit, cmp;
  logic [15:0] oofs;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ofs_predictor i_ofs_predictor (
    .clk(clk), .rst(rst), .enable_i(en), .acc_valid_i(vld), .acc_chan_i(ch),
    .acc_ofs_i(ofs), .rx_mode_i(rxm), .rx_compact_i(rxc),
    .out_valid_o(ov), .hit_o(hit), .ofs_o(oofs), .compact_o(cmp)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vld = 1'b0; en = 1'b1; rxm = 1'b0; rxc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one access, result sampled at the negedge after the capturing edge
  task automatic access(input string req, input int c, input int o, input logic rx,
                        input logic comp, input logic exp_hit, input int exp_ofs);
    ch = 2'(c); ofs = 16'(o); rxm = rx; rxc = comp; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check(req, "out_valid", int'(ov), 1);
    check(req, "hit", int'(hit), int'(exp_hit));
    check(req, "compact", int'(cmp), int'(exp_hit & en));
    check(req, "ofs", int'(oofs), exp_ofs);
  endtask

  task automatic t_reset();
    do_reset();
    check("R9", "out_valid after reset", int'(ov), 0);
    for (int i = 0; i < 4; i++) access("R9", i, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h1234);
    @(negedge clk);
    check("R1", "idle cycle", int'(ov), 0);
  endtask

  task automatic t_stride();
    do_reset();
    access("R3", 0, 100, 0, 0, 0, 100);
    access("R3", 0, 104, 0, 0, 0, 104);
    access("R3", 0, 108, 0, 0, 0, 108);
    access("R3", 0, 112, 0, 0, 1, 112);
    access("R4", 0, 116, 0, 0, 1, 116);
    access("R5", 0, 200, 0, 0, 0, 200);
    access("R5", 0, 284, 0, 0, 0, 284);
    access("R5", 0, 368, 0, 0, 1, 368);
  endtask

  task automatic t_interleave();
    do_reset();
    for (int k = 0; k < 5; k++) begin
      access("R2", 1, 1000 + 8*k, 0, 0, k >= 3, 1000 + 8*k);
      access("R2", 2, 3000 - 4*k, 0, 0, k >= 3, 3000 - 4*k);
    end
  endtask

  task automatic t_limit();
    do_reset();
    for (int k = 0; k < 4; k++) access("R6", 3, 512*k, 0, 0, k == 3, 512*k);
    for (int k = 0; k < 4; k++) access("R6", 2, 513*k, 0, 0, 0, 513*k);
    for (int k = 0; k < 4; k++) access("R6", 1, 2000 - 512*k, 0, 0, k == 3, 2000 - 512*k);
    for (int k = 0; k < 4; k++) access("R6", 0, 4000 - 513*k, 0, 0, 0, 4000 - 513*k);
  endtask

  task automatic t_wrap();
    do_reset();
    access("R11", 0, 16'hFFE0, 0, 0, 0, 16'hFFE0);
    access("R11", 0, 16'hFFF0, 0, 0, 0, 16'hFFF0);
    access("R11", 0, 16'h0000, 0, 0, 0, 16'h0000);
    access("R11", 0, 16'h0010, 0, 0, 1, 16'h0010);
  endtask

  task automatic t_rx();
    do_reset();
    access("R8", 0, 10, 1, 0, 0, 10);
    access("R8", 0, 20, 1, 0, 0, 20);
    access("R8", 0, 30, 1, 0, 0, 30);
    access("R7", 0, 16'hDEAD, 1, 1, 1, 40);
    access("R7", 0, 16'hBEEF, 1, 1, 1, 50);
    access("R7", 0, 60, 1, 0, 1, 60);
  endtask

  task automatic t_enable();
    do_reset();
    en = 1'b0;
    for (int k = 0; k < 5; k++) access("R10", 2, 64*k, 0, 0, k >= 3, 64*k);
    en = 1'b1;
    access("R10", 2, 320, 0, 0, 1, 320);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_stride();
        t_interleave();
        t_limit();
        t_wrap();
        t_rx();
        t_enable();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule